// File: doc/BRIEF.md
# Tiled Matrix-Multiply Sequencer

This controller lets an N×N weight-stationary multiply array compute C = A·B for operands larger than the array. A is M×K, B is K×P, and C is M×P. The sizes M, K and P arrive as runtime inputs together with a one-cycle start pulse. The controller cuts the work into output patches of N×N. For each output patch it runs one pass per N-wide slice of the K dimension. A pass first loads the B slice into the array as weights, one weight row per cycle. It then streams the matching rows of A, and each row's lanes are indexed by k.

Partial sums are carried from one K-slice to the next through the array's top-edge addend port. On the first slice the addend is zero. On every later slice it is the partial C row that the previous slice wrote into the C buffer. When a dimension is not a multiple of N, the edge patches are padded. Lanes that fall outside the matrix are forced to zero rather than taken from memory, and the matching C lanes are never written. Rows of A beyond M are not streamed at all.

The operand and C buffers are synchronous read ports. Data returns in the cycle after the address. The controller presents that data to the array in the same cycle it returns. It writes each result row that the array hands back to the C port.

Top module: `tiled_gemm_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, every read enable and `c_we` are low, and they stay low until `start`.
- R2: Output patches are visited in row-major order (patch row `mt`, then patch column `pt`), and the K-slices `kt` of each patch run in ascending order. Each pass begins in the cycle after `start`, or in the cycle after the previous pass's drain ends.
- R3: A pass starts with exactly N cycles of B reads, one per cycle. In cycle r the read is at row `kt*N+r` and column `pt*N`. The read data is presented on `arr_wrow` with `arr_wvalid` one cycle later, and all N weight rows are presented before any A row of that pass.
- R4: After the weight reads, the A rows `mt*N+i` for i from 0 to min(N, M−mt*N)−1 are read one per cycle at column `kt*N`. Each row is presented on `arr_avec` with `arr_avalid` one cycle after its read.
- R5: A lane j is forced to zero when its index is out of range. For `arr_avec` that means `kt*N+j ≥ K`. For `arr_wrow` it means the weight row is at `kt*N+r ≥ K` or its column `pt*N+j ≥ P`. For `arr_dvec` it means `pt*N+j ≥ P`. C lanes with `pt*N+j ≥ P` are never written.
- R6: On slice `kt=0` no C read is issued and `arr_dvec` is zero. On later slices each A read is paired with a C read of the same row at column `pt*N`, and that data becomes the addend.
- R7: Each `arr_rvalid` result is written through `c_we` in the same cycle, at row `mt*N` plus the count of results already returned in this pass, and at column `pt*N`. `c_last` is high exactly for writes of the final K-slice.
- R8: The next pass's weight loading begins in the cycle after the last result of the current pass is written. No B read is issued while any A row read is still waiting for its result.
- R9: `done` is a single-cycle pulse, one cycle after the final write. When M, K or P is zero, `done` pulses in the cycle after `start` and no memory access takes place.
- R10: On completion, the C buffer holds the product of A and B for every element with i<M and j<P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run with the given sizes |
| dim_m | input | DIMW | Rows of A and C |
| dim_k | input | DIMW | Columns of A, rows of B |
| dim_p | input | DIMW | Columns of B and C |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Pulse when the run is complete |
| a_re | output | 1 | A read enable |
| a_row | output | DIMW | A read row |
| a_col | output | DIMW | A read first column |
| a_rdata | input | N*DW | N A elements, lane j at column a_col+j |
| b_re | output | 1 | B read enable |
| b_row | output | DIMW | B read row |
| b_col | output | DIMW | B read first column |
| b_rdata | input | N*DW | N B elements |
| c_re | output | 1 | C read enable (addend) |
| c_rrow | output | DIMW | C read row |
| c_rcol | output | DIMW | C read first column |
| c_rdata | input | N*ACCW | N partial C elements |
| c_we | output | 1 | C write enable |
| c_wrow | output | DIMW | C write row |
| c_wcol | output | DIMW | C write first column |
| c_wdata | output | N*ACCW | Result row |
| c_wmask | output | N | Per-lane write enable |
| c_last | output | 1 | Write belongs to the final K-slice |
| arr_wvalid | output | 1 | Weight row valid into the array |
| arr_wrow | output | N*DW | Weight row, lanes are output columns |
| arr_avalid | output | 1 | A row valid into the array |
| arr_avec | output | N*DW | A row, lanes are k indices |
| arr_dvec | output | N*ACCW | Top-edge addend row |
| arr_rvalid | input | 1 | Result row valid from the array |
| arr_rvec | input | N*ACCW | Result row from the array |

## Verification
The sizes tried are the following, and each one separates a different class of fault:
- **8×8×8** fills every patch exactly with two K-slices, so it exercises the addend feedback without any padding.
- **6×5×7** leaves a partial edge in every dimension, which exposes missing lane masks and wrong row counts.
- **3×3×3** fits in one patch with a single slice, where an addend read or a spurious `c_last` would stand out.
- **9×10×6** runs three K-slices over three patch rows, which tests slice ordering and carrying a sum across more than one pass.
- **A zero dimension** must produce only the done pulse.

Out-of-range memory words hold nonzero filler, so any unmasked lane changes either the presented data or the final product.

// File: rtl/tiled_gemm_seq.sv
module tiled_gemm_seq #(
  parameter int N    = 4,
  parameter int DW   = 8,
  parameter int ACCW = 32,
  parameter int DIMW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIMW-1:0]   dim_m,
  input  logic [DIMW-1:0]   dim_k,
  input  logic [DIMW-1:0]   dim_p,
  output logic              busy,
  output logic              done,
  output logic              a_re,
  output logic [DIMW-1:0]   a_row,
  output logic [DIMW-1:0]   a_col,
  input  logic [N*DW-1:0]   a_rdata,
  output logic              b_re,
  output logic [DIMW-1:0]   b_row,
  output logic [DIMW-1:0]   b_col,
  input  logic [N*DW-1:0]   b_rdata,
  output logic              c_re,
  output logic [DIMW-1:0]   c_rrow,
  output logic [DIMW-1:0]   c_rcol,
  input  logic [N*ACCW-1:0] c_rdata,
  output logic              c_we,
  output logic [DIMW-1:0]   c_wrow,
  output logic [DIMW-1:0]   c_wcol,
  output logic [N*ACCW-1:0] c_wdata,
  output logic [N-1:0]      c_wmask,
  output logic              c_last,
  output logic              arr_wvalid,
  output logic [N*DW-1:0]   arr_wrow,
  output logic              arr_avalid,
  output logic [N*DW-1:0]   arr_avec,
  output logic [N*ACCW-1:0] arr_dvec,
  input  logic              arr_rvalid,
  input  logic [N*ACCW-1:0] arr_rvec
);
  localparam logic [DIMW-1:0] NV = DIMW'(N);
  localparam logic [DIMW:0]   NW = (DIMW+1)'(N);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_STREAM, S_DRAIN, S_DONE} state_t;
  state_t st;

  logic [DIMW-1:0] m_q, k_q, p_q;
  logic [DIMW-1:0] mt, pt, kt, cnt, wcnt;
  logic            ld_q, st_q, brow_q;

  logic [DIMW:0]   mn, kn, pn;
  logic [DIMW-1:0] mbase, kbase, pbase, rem_m, ra;
  logic [N-1:0]    kmask, pmask;
  logic            kt_last, pt_last, mt_last, slice_end, any_zero;

  assign mn = ({1'b0, m_q} + NW - 1'b1) / NW;
  assign kn = ({1'b0, k_q} + NW - 1'b1) / NW;
  assign pn = ({1'b0, p_q} + NW - 1'b1) / NW;

  assign mbase = DIMW'(mt * NV);
  assign kbase = DIMW'(kt * NV);
  assign pbase = DIMW'(pt * NV);
  assign rem_m = m_q - mbase;
  assign ra    = (rem_m >= NV) ? NV : rem_m;

  assign kt_last   = ({1'b0, kt} == kn - 1'b1);
  assign pt_last   = ({1'b0, pt} == pn - 1'b1);
  assign mt_last   = ({1'b0, mt} == mn - 1'b1);
  assign slice_end = (st == S_DRAIN) && arr_rvalid && (wcnt == ra - 1'b1);
  assign any_zero  = (dim_m == '0) || (dim_k == '0) || (dim_p == '0);

  for (genvar j = 0; j < N; j++) begin : g_lane
    assign kmask[j] = ({1'b0, kbase} + (DIMW+1)'(j)) < {1'b0, k_q};
    assign pmask[j] = ({1'b0, pbase} + (DIMW+1)'(j)) < {1'b0, p_q};
    assign arr_wrow[j*DW +: DW]   = (brow_q && pmask[j]) ? b_rdata[j*DW +: DW] : '0;
    assign arr_avec[j*DW +: DW]   = (st_q && kmask[j]) ? a_rdata[j*DW +: DW] : '0;
    assign arr_dvec[j*ACCW +: ACCW] = (st_q && kt != '0 && pmask[j]) ? c_rdata[j*ACCW +: ACCW] : '0;
  end

  assign busy   = (st != S_IDLE);
  assign done   = (st == S_DONE);
  assign b_re   = (st == S_LOAD);
  assign b_row  = kbase + cnt;
  assign b_col  = pbase;
  assign a_re   = (st == S_STREAM);
  assign a_row  = mbase + cnt;
  assign a_col  = kbase;
  assign c_re   = (st == S_STREAM) && (kt != '0);
  assign c_rrow = mbase + cnt;
  assign c_rcol = pbase;

  assign c_we    = arr_rvalid;
  assign c_wrow  = mbase + wcnt;
  assign c_wcol  = pbase;
  assign c_wdata = arr_rvec;
  assign c_wmask = pmask;
  assign c_last  = kt_last;

  assign arr_wvalid = ld_q;
  assign arr_avalid = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q   <= 1'b0;
      st_q   <= 1'b0;
      brow_q <= 1'b0;
    end else begin
      ld_q   <= b_re;
      st_q   <= a_re;
      brow_q <= b_re && ({1'b0, b_row} < {1'b0, k_q});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      m_q  <= '0;
      k_q  <= '0;
      p_q  <= '0;
      mt   <= '0;
      pt   <= '0;
      kt   <= '0;
      cnt  <= '0;
      wcnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          m_q <= dim_m;
          k_q <= dim_k;
          p_q <= dim_p;
          mt  <= '0;
          pt  <= '0;
          kt  <= '0;
          cnt <= '0;
          wcnt <= '0;
          st  <= any_zero ? S_DONE : S_LOAD;
        end
        S_LOAD: begin
          if (cnt == NV - 1'b1) begin
            cnt <= '0;
            st  <= S_STREAM;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STREAM: begin
          if (cnt == ra - 1'b1) begin
            cnt <= '0;
            st  <= S_DRAIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DRAIN: if (slice_end) begin
          st <= S_LOAD;
          if (!kt_last) begin
            kt <= kt + 1'b1;
          end else begin
            kt <= '0;
            if (!pt_last) begin
              pt <= pt + 1'b1;
            end else begin
              pt <= '0;
              if (!mt_last) mt <= mt + 1'b1;
              else          st <= S_DONE;
            end
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase

      if (slice_end)       wcnt <= '0;
      else if (arr_rvalid) wcnt <= wcnt + 1'b1;
    end
  end
endmodule

// File: rtl/tiled_gemm_seq_chk.sv
module tiled_gemm_seq_chk #(
  parameter int N    = 4,
  parameter int ACCW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              a_re,
  input logic              b_re,
  input logic              c_re,
  input logic              c_we,
  input logic [N-1:0]      c_wmask,
  input logic              arr_wvalid,
  input logic              arr_avalid,
  input logic [N*ACCW-1:0] arr_dvec
);
  logic [15:0] wseen;
  logic [15:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wseen <= '0;
      pend  <= '0;
    end else begin
      if (arr_avalid)      wseen <= '0;
      else if (arr_wvalid) wseen <= wseen + 1'b1;
      pend <= pend + {15'd0, a_re} - {15'd0, c_we};
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(a_re || b_re || c_re || c_we));

  assert_one_operand_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_re, b_re}));

  assert_weights_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_avalid) |-> (wseen == 16'(N)));

  assert_first_addend_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_avalid && !$past(c_re)) |-> (arr_dvec == '0));

  assert_write_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    c_we |-> (c_wmask != '0) && busy);

  assert_drained_before_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    b_re |-> (pend == '0));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_drained_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pend == '0));
endmodule

bind tiled_gemm_seq tiled_gemm_seq_chk #(.N(N), .ACCW(ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .a_re(a_re), .b_re(b_re), .c_re(c_re), .c_we(c_we), .c_wmask(c_wmask),
  .arr_wvalid(arr_wvalid), .arr_avalid(arr_avalid), .arr_dvec(arr_dvec)
);

// File: tb/tiled_gemm_seq_tb.sv
module tiled_gemm_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int DW   = 8;
  localparam int ACCW = 32;
  localparam int DIMW = 8;
  localparam int LAT  = 3;
  localparam int MD   = 16;
  localparam int MAXC = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DIMW-1:0] dim_m = '0, dim_k = '0, dim_p = '0;
  logic busy, done;
  logic a_re, b_re, c_re, c_we, c_last;
  logic [DIMW-1:0] a_row, a_col, b_row, b_col, c_rrow, c_rcol, c_wrow, c_wcol;
  logic [N*DW-1:0] a_rdata, b_rdata;
  logic [N*ACCW-1:0] c_rdata, c_wdata;
  logic [N-1:0] c_wmask;
  logic arr_wvalid, arr_avalid;
  logic [N*DW-1:0] arr_wrow, arr_avec;
  logic [N*ACCW-1:0] arr_dvec;
  logic arr_rvalid;
  logic [N*ACCW-1:0] arr_rvec;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiled_gemm_seq #(.N(N), .DW(DW), .ACCW(ACCW), .DIMW(DIMW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dim_m(dim_m), .dim_k(dim_k), .dim_p(dim_p),
    .busy(busy), .done(done),
    .a_re(a_re), .a_row(a_row), .a_col(a_col), .a_rdata(a_rdata),
    .b_re(b_re), .b_row(b_row), .b_col(b_col), .b_rdata(b_rdata),
    .c_re(c_re), .c_rrow(c_rrow), .c_rcol(c_rcol), .c_rdata(c_rdata),
    .c_we(c_we), .c_wrow(c_wrow), .c_wcol(c_wcol), .c_wdata(c_wdata), .c_wmask(c_wmask),
    .c_last(c_last),
    .arr_wvalid(arr_wvalid), .arr_wrow(arr_wrow), .arr_avalid(arr_avalid),
    .arr_avec(arr_avec), .arr_dvec(arr_dvec), .arr_rvalid(arr_rvalid), .arr_rvec(arr_rvec)
  );

  logic [DW-1:0]   amem [MD][MD];
  logic [DW-1:0]   bmem [MD][MD];
  logic [ACCW-1:0] cmem [MD][MD];
  logic [DW-1:0]   wt [N][N];
  int wp = 0;
  logic            pv [LAT];
  logic [ACCW-1:0] pr [LAT][N];

  function automatic logic [DW-1:0] rd_a(int r, int c);
    return (r < MD && c < MD) ? amem[r][c] : 8'hA5;
  endfunction
  function automatic logic [DW-1:0] rd_b(int r, int c);
    return (r < MD && c < MD) ? bmem[r][c] : 8'hA5;
  endfunction
  function automatic logic [ACCW-1:0] rd_c(int r, int c);
    return (r < MD && c < MD) ? cmem[r][c] : 32'h0BAD;
  endfunction

  always @(posedge clk) begin
    for (int j = 0; j < N; j++) begin
      a_rdata[j*DW +: DW]     <= rd_a(int'(a_row), int'(a_col) + j);
      b_rdata[j*DW +: DW]     <= rd_b(int'(b_row), int'(b_col) + j);
      c_rdata[j*ACCW +: ACCW] <= rd_c(int'(c_rrow), int'(c_rcol) + j);
    end
    if (c_we)
      for (int j = 0; j < N; j++)
        if (c_wmask[j] && int'(c_wrow) < MD && int'(c_wcol) + j < MD)
          cmem[c_wrow][int'(c_wcol) + j] <= c_wdata[j*ACCW +: ACCW];
  end

  // behavioural array: N weight rows loaded in order, result after LAT cycles
  always @(posedge clk) begin
    if (arr_wvalid) begin
      for (int j = 0; j < N; j++) wt[wp][j] <= arr_wrow[j*DW +: DW];
      wp <= (wp + 1) % N;
    end
    pv[0] <= arr_avalid;
    for (int j = 0; j < N; j++) begin
      logic [ACCW-1:0] acc;
      acc = arr_dvec[j*ACCW +: ACCW];
      for (int r = 0; r < N; r++) acc = acc + ACCW'(arr_avec[r*DW +: DW]) * ACCW'(wt[r][j]);
      pr[0][j] <= acc;
    end
    for (int s = 1; s < LAT; s++) begin
      pv[s] <= pv[s-1];
      for (int j = 0; j < N; j++) pr[s][j] <= pr[s-1][j];
    end
  end
  always_comb begin
    arr_rvalid = rst_n && pv[LAT-1];
    for (int j = 0; j < N; j++) arr_rvec[j*ACCW +: ACCW] = pr[LAT-1][j];
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  logic [50:0] erd [MAXC];
  logic [25:0] ewr [MAXC];
  logic        edn [MAXC];
  int elen;

  task automatic build(input int m, input int k, input int p);
    int t, mn, kn, pn, ra;
    for (int c = 0; c < MAXC; c++) begin erd[c] = '0; ewr[c] = '0; edn[c] = 1'b0; end
    t = 0;
    if (m == 0 || k == 0 || p == 0) begin
      edn[0] = 1'b1; elen = 1; return;
    end
    mn = (m + N - 1) / N; kn = (k + N - 1) / N; pn = (p + N - 1) / N;
    for (int mt = 0; mt < mn; mt++)
      for (int pt = 0; pt < pn; pt++)
        for (int kt = 0; kt < kn; kt++) begin
          for (int r = 0; r < N; r++) begin
            erd[t] = {1'b1, 8'(kt*N + r), 8'(pt*N), 1'b0, 16'd0, 1'b0, 16'd0};
            t++;
          end
          ra = (m - mt*N >= N) ? N : m - mt*N;
          for (int i = 0; i < ra; i++) begin
            erd[t] = {17'd0, 1'b1, 8'(mt*N + i), 8'(kt*N), kt > 0,
                      (kt > 0) ? 8'(mt*N + i) : 8'd0, (kt > 0) ? 8'(pt*N) : 8'd0};
            ewr[t+1+LAT] = {1'b1, 8'(mt*N + i), 8'(pt*N), kt == kn - 1, 8'd0};
            t++;
          end
          t += LAT + 1;
        end
    edn[t] = 1'b1;
    elen = t + 1;
  endtask

  task automatic fill(input int m, input int k, input int p, input int seed);
    for (int r = 0; r < MD; r++)
      for (int c = 0; c < MD; c++) begin
        amem[r][c] = (r < m && c < k) ? DW'((r*3 + c*5 + seed) % 11) : 8'hC8;
        bmem[r][c] = (r < k && c < p) ? DW'((r*7 + c*2 + seed) % 9) : 8'hC8;
        cmem[r][c] = 32'hFFFF_FFF9;
      end
  endtask

  task automatic run(input int m, input int k, input int p, input int seed);
    logic pa, pb, pc, pfirst;
    int parow, pacol, pbrow, pbcol, pcol;
    logic [50:0] grd;
    logic [25:0] gwr;
    logic [DW-1:0] ex8;
    fill(m, k, p, seed);
    build(m, k, p);
    @(negedge clk);
    dim_m = DIMW'(m); dim_k = DIMW'(k); dim_p = DIMW'(p);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pa = 0; pb = 0; pc = 0; pfirst = 0; parow = 0; pacol = 0; pbrow = 0; pbcol = 0; pcol = 0;
    for (int c = 0; c < elen + 2; c++) begin
      grd = {b_re, b_re ? b_row : 8'd0, b_re ? b_col : 8'd0,
             a_re, a_re ? a_row : 8'd0, a_re ? a_col : 8'd0,
             c_re, c_re ? c_rrow : 8'd0, c_re ? c_rcol : 8'd0};
      gwr = {c_we, c_we ? c_wrow : 8'd0, c_we ? c_wcol : 8'd0, c_we ? c_last : 1'b0, 8'd0};
      check(grd == erd[c], "R2 R4 read order", 64'(grd), 64'(erd[c]));
      check(gwr == ewr[c], "R7 write row and last flag", 64'(gwr), 64'(ewr[c]));
      check(done == edn[c], "R9 done timing", 64'(done), 64'(edn[c]));
      check(arr_wvalid == pb && arr_avalid == pa, "R3 R4 presentation valid",
            64'({arr_wvalid, arr_avalid}), 64'({pb, pa}));
      if (pb)
        for (int j = 0; j < N; j++) begin
          ex8 = (pbrow < k && pbcol + j < p) ? rd_b(pbrow, pbcol + j) : 8'd0;
          check(arr_wrow[j*DW +: DW] == ex8, "R3 R5 weight lane", 64'(arr_wrow[j*DW +: DW]), 64'(ex8));
        end
      if (pa) begin
        for (int j = 0; j < N; j++) begin
          ex8 = (pacol + j < k) ? rd_a(parow, pacol + j) : 8'd0;
          check(arr_avec[j*DW +: DW] == ex8, "R4 R5 A lane", 64'(arr_avec[j*DW +: DW]), 64'(ex8));
        end
        if (pfirst) check(arr_dvec == '0, "R6 first slice addend zero", 64'(arr_dvec), 64'd0);
        check(pc == !pfirst, "R6 addend read pairing", 64'(pc), 64'(!pfirst));
      end
      pa = a_re; pb = b_re; pc = c_re; pfirst = (a_col == 0);
      parow = int'(a_row); pacol = int'(a_col); pbrow = int'(b_row); pbcol = int'(b_col); pcol = int'(c_rcol);
      @(negedge clk);
    end
    check(!busy, "R9 idle after done", 64'(busy), 64'd0);
    for (int i = 0; i < MD; i++)
      for (int j = 0; j < MD; j++) begin
        logic [ACCW-1:0] ref_v;
        if (i < m && j < p && k > 0) begin
          ref_v = '0;
          for (int q = 0; q < k; q++) ref_v = ref_v + ACCW'(amem[i][q]) * ACCW'(bmem[q][j]);
          check(cmem[i][j] == ref_v, "R10 product element", 64'(cmem[i][j]), 64'(ref_v));
        end else if (cmem[i][j] != 32'hFFFF_FFF9) begin
          check(1'b0, "R5 write outside matrix", 64'(cmem[i][j]), 64'hFFFF_FFF9);
        end
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !a_re && !b_re && !c_re && !c_we, "R1 reset state",
          64'({busy, done, a_re, b_re, c_re, c_we}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !a_re && !b_re && !c_re && !c_we, "R1 idle before start",
          64'({busy, a_re, b_re, c_re, c_we}), 64'd0);
    run(8, 8, 8, 1);
    run(6, 5, 7, 2);
    run(3, 3, 3, 3);
    run(9, 10, 6, 4);
    run(0, 4, 4, 5);
    run(5, 0, 3, 6);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule